// File: doc/BRIEF.md
# Doorbell Ring Mailbox

This block carries 32-bit words one way, from a host agent to an embedded controller, through a circular buffer of slots. Each side has its own register port. The host pushes words through a write window. The controller pops them in arrival order through a read window. Each side owns a control/status register. That register holds the side's interrupt enable, interrupt status, doorbell, ready and reset bits. It also shows the shared 8-bit read pointer, the 8-bit write pointer and the buffer depth.

Software on either side works out the fill level as the write pointer minus the read pointer, modulo 256. The free space is the depth field minus that fill level. Setting the doorbell bit raises interrupt status on the other side. Setting the reset bit empties the buffer and drops both ready bits, and the two sides then set ready again.

The register ports have no back-pressure. Every read or write is taken in the cycle it is presented. Read data is combinational on the address in that same cycle. A pop takes effect at the clock edge that ends the access.

Top module: `doorbell_ring_mbox`

## Requirements
- R1: After reset, both status registers read 0x08000000: depth 8 in bits 31:24, both pointers 0, all control bits 0. Both interrupt outputs are low.
- R2: A host write to offset 0x0 while the buffer is not full and no reset is active stores the word and advances the write pointer (status bits 23:16) by one.
- R3: The fill level, write pointer minus read pointer truncated to 8 bits, never exceeds the depth. It stays correct across pointer wrap from 255 to 0. The free space is the depth field minus the fill level.
- R4: Controller reads of offset 0x8 with the pop strobe return the stored words in write order and advance the read pointer (bits 15:8) by one each.
- R5: A pop from an empty buffer returns 0 and leaves the read pointer unchanged.
- R6: A host write to a full buffer is dropped and sets the sticky overflow bit, bit 5 of the host status register. The host clears that bit by writing 1 to bit 5.
- R7: Writing 1 to bit 2 (doorbell) reads back as 1 for exactly one cycle. In the following cycle, bit 1 (interrupt status) of the other side's register becomes 1.
- R8: Writing 1 to bit 1 of a side's own register clears its interrupt status. Writing 0 there leaves it unchanged.
- R9: Each side's interrupt output is high exactly when that side's bit 0 (enable) and bit 1 (status) are both 1.
- R10: Writing 1 to bit 4 (reset) zeroes both pointers, clears both ready bits (bit 3) and clears overflow. While either reset bit stays 1, host window writes are dropped.
- R11: A side's ready bit changes only on that side's own register writes or on a reset request. The other side can read it through the register of the writing side, at offset 0x4 for the host and 0xC for the controller.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| h_addr | input | 4 | Host register offset |
| h_wr | input | 1 | Host write strobe |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data (status at 0x4 and 0xC) |
| c_addr | input | 4 | Controller register offset |
| c_wr | input | 1 | Controller write strobe |
| c_rd | input | 1 | Controller read strobe; pops at offset 0x8 |
| c_wdata | input | 5 | Controller status write data, bits 4:0 |
| c_rdata | output | 32 | Controller read data |
| h_irq | output | 1 | Host interrupt |
| c_irq | output | 1 | Controller interrupt |

## Verification
A corrupted pointer shows at once in the status pointer fields. It shows again on the next pop, as a word out of order or a zero where data was expected. An interrupt bit stuck high or low shows as a wrong interrupt output, or a wrong bit 1, one cycle after the doorbell that should have changed it. A reset handshake that leaves stale state shows in the next status read, because the pointers fail to read zero or a ready bit survives. Each of these is visible within two cycles of the access that should have caused it.

// File: rtl/dbm_pkg.sv
package dbm_pkg;
  localparam int WORD_W = 32;
  localparam int PTR_W  = 8;

  localparam logic [3:0] OFS_TXWIN = 4'h0;
  localparam logic [3:0] OFS_HCSR  = 4'h4;
  localparam logic [3:0] OFS_RXWIN = 4'h8;
  localparam logic [3:0] OFS_CCSR  = 4'hC;

  localparam int B_IE  = 0;
  localparam int B_IS  = 1;
  localparam int B_GEN = 2;
  localparam int B_RDY = 3;
  localparam int B_RST = 4;
  localparam int B_OVF = 5;

  typedef struct packed {
    logic rst;
    logic rdy;
    logic gen;
    logic is;
    logic ie;
  } side_t;

  function automatic logic [WORD_W-1:0] pack_csr(side_t s, logic ovf,
                                                 logic [PTR_W-1:0] rp,
                                                 logic [PTR_W-1:0] wp,
                                                 logic [PTR_W-1:0] dep);
    return {dep, wp, rp, 2'b00, ovf, s.rst, s.rdy, s.gen, s.is, s.ie};
  endfunction
endpackage

// File: rtl/dbm_side.sv
module dbm_side
  import dbm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       csr_wr,
  input  logic [4:0] wbits,
  input  logic       peer_gen,
  input  logic       link_clr,
  output side_t      st,
  output logic       irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= '0;
    end else begin
      st.gen <= csr_wr & wbits[B_GEN];
      st.is  <= (st.is & ~(csr_wr & wbits[B_IS])) | peer_gen;
      if (csr_wr) begin
        st.ie  <= wbits[B_IE];
        st.rst <= wbits[B_RST];
      end
      if (link_clr)
        st.rdy <= 1'b0;
      else if (csr_wr)
        st.rdy <= wbits[B_RDY];
    end
  end

  assign irq = st.ie & st.is;
endmodule

// File: rtl/dbm_ring.sv
module dbm_ring
  import dbm_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic [WORD_W-1:0] push_data,
  input  logic              pop,
  input  logic              ovf_clr,
  output logic [PTR_W-1:0]  wr_ptr,
  output logic [PTR_W-1:0]  rd_ptr,
  output logic [WORD_W-1:0] head,
  output logic              full,
  output logic              empty,
  output logic              ovf
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] DEP_V = PTR_W'(DEPTH);

  logic [WORD_W-1:0] slots [DEPTH];
  logic [PTR_W-1:0]  fill;

  assign fill  = wr_ptr - rd_ptr;
  assign full  = (fill == DEP_V);
  assign empty = (fill == '0);
  assign head  = slots[rd_ptr[IW-1:0]];

  always_ff @(posedge clk) begin
    if (push && !full && !flush)
      slots[wr_ptr[IW-1:0]] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      ovf    <= 1'b0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      ovf    <= 1'b0;
    end else begin
      if (push && !full) wr_ptr <= wr_ptr + 1'b1;
      if (pop && !empty) rd_ptr <= rd_ptr + 1'b1;
      if (push && full)  ovf <= 1'b1;
      else if (ovf_clr)  ovf <= 1'b0;
    end
  end
endmodule

// File: rtl/doorbell_ring_mbox.sv
module doorbell_ring_mbox
  import dbm_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  h_addr,
  input  logic        h_wr,
  input  logic [31:0] h_wdata,
  output logic [31:0] h_rdata,
  input  logic [3:0]  c_addr,
  input  logic        c_wr,
  input  logic        c_rd,
  input  logic [4:0]  c_wdata,
  output logic [31:0] c_rdata,
  output logic        h_irq,
  output logic        c_irq
);
  localparam logic [PTR_W-1:0] DEP_V = PTR_W'(DEPTH);

  logic h_csr_wr, c_csr_wr, h_push, c_pop, rst_evt, hold;
  side_t h_st, c_st;
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [WORD_W-1:0] head, h_csr, c_csr;
  logic full, empty, ovf;

  assign h_csr_wr = h_wr && (h_addr == OFS_HCSR);
  assign c_csr_wr = c_wr && (c_addr == OFS_CCSR);
  assign h_push   = h_wr && (h_addr == OFS_TXWIN);
  assign c_pop    = c_rd && (c_addr == OFS_RXWIN);
  assign rst_evt  = (h_csr_wr && h_wdata[B_RST]) || (c_csr_wr && c_wdata[B_RST]);
  assign hold     = rst_evt || h_st.rst || c_st.rst;

  dbm_side u_hside (
    .clk(clk), .rst_n(rst_n), .csr_wr(h_csr_wr), .wbits(h_wdata[4:0]),
    .peer_gen(c_st.gen), .link_clr(rst_evt), .st(h_st), .irq(h_irq)
  );

  dbm_side u_cside (
    .clk(clk), .rst_n(rst_n), .csr_wr(c_csr_wr), .wbits(c_wdata),
    .peer_gen(h_st.gen), .link_clr(rst_evt), .st(c_st), .irq(c_irq)
  );

  dbm_ring #(.DEPTH(DEPTH)) u_ring (
    .clk(clk), .rst_n(rst_n), .flush(hold), .push(h_push), .push_data(h_wdata),
    .pop(c_pop), .ovf_clr(h_csr_wr && h_wdata[B_OVF]),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .head(head),
    .full(full), .empty(empty), .ovf(ovf)
  );

  assign h_csr = pack_csr(h_st, ovf, rd_ptr, wr_ptr, DEP_V);
  assign c_csr = pack_csr(c_st, 1'b0, rd_ptr, wr_ptr, DEP_V);

  always_comb begin
    unique case (h_addr)
      OFS_HCSR: h_rdata = h_csr;
      OFS_CCSR: h_rdata = c_csr;
      default:  h_rdata = '0;
    endcase
  end

  always_comb begin
    unique case (c_addr)
      OFS_RXWIN: c_rdata = empty ? '0 : head;
      OFS_HCSR:  c_rdata = h_csr;
      OFS_CCSR:  c_rdata = c_csr;
      default:   c_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dbm_checker.sv
module dbm_checker #(
  parameter int DEPTH = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  h_addr,
  input logic        h_wr,
  input logic [31:0] h_wdata,
  input logic [31:0] h_rdata,
  input logic [3:0]  c_addr,
  input logic        c_rd,
  input logic [31:0] c_rdata,
  input logic        h_irq,
  input logic        hold,
  input logic [7:0]  wr_ptr,
  input logic [7:0]  rd_ptr,
  input logic        ovf,
  input logic        h_gen,
  input logic        c_gen,
  input logic        h_is,
  input logic        c_is,
  input logic        h_rdy,
  input logic        c_rdy
);
  logic [7:0] fill;
  assign fill = 8'(wr_ptr - rd_ptr);

  assert_fill_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= 8'(DEPTH));

  assert_push_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && h_addr == 4'h0 && !hold && fill != 8'(DEPTH))
      |=> wr_ptr == 8'($past(wr_ptr) + 8'd1));

  assert_empty_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (c_rd && c_addr == 4'h8 && !hold && fill == 8'd0)
      |-> c_rdata == 32'd0 ##1 rd_ptr == $past(rd_ptr));

  assert_full_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && h_addr == 4'h0 && !hold && fill == 8'(DEPTH))
      |=> (wr_ptr == $past(wr_ptr) && ovf));

  assert_host_bell_R7: assert property (@(posedge clk) disable iff (!rst_n)
    h_gen |=> c_is);

  assert_ctrl_bell_R7: assert property (@(posedge clk) disable iff (!rst_n)
    c_gen |=> h_is);

  assert_irq_view_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (h_addr == 4'h4) |-> h_irq == (h_rdata[0] & h_rdata[1]));

  assert_reset_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && h_addr == 4'h4 && h_wdata[4])
      |=> (wr_ptr == 8'd0 && rd_ptr == 8'd0 && !h_rdy && !c_rdy && !ovf));
endmodule

bind doorbell_ring_mbox dbm_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .h_addr(h_addr), .h_wr(h_wr), .h_wdata(h_wdata),
  .h_rdata(h_rdata), .c_addr(c_addr), .c_rd(c_rd), .c_rdata(c_rdata),
  .h_irq(h_irq), .hold(hold), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .ovf(ovf),
  .h_gen(h_st.gen), .c_gen(c_st.gen), .h_is(h_st.is), .c_is(c_st.is),
  .h_rdy(h_st.rdy), .c_rdy(c_st.rdy)
);

// File: tb/doorbell_ring_mbox_bench.sv
`timescale 1ns/100ps
module doorbell_ring_mbox_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  h_addr = 4'h4;
  logic        h_wr = 1'b0;
  logic [31:0] h_wdata = '0;
  logic [31:0] h_rdata;
  logic [3:0]  c_addr = 4'hC;
  logic        c_wr = 1'b0;
  logic        c_rd = 1'b0;
  logic [4:0]  c_wdata = '0;
  logic [31:0] c_rdata;
  logic        h_irq, c_irq;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;
  logic [31:0] hs, cs;
  logic hirq_s, cirq_s;
  logic [31:0] exp_q[$];
  logic [31:0] got_q[$];

  always #2.5 clk = ~clk;

  doorbell_ring_mbox u_doorbell_ring_mbox (
    .clk(clk), .rst_n(rst_n), .h_addr(h_addr), .h_wr(h_wr), .h_wdata(h_wdata),
    .h_rdata(h_rdata), .c_addr(c_addr), .c_wr(c_wr), .c_rd(c_rd),
    .c_wdata(c_wdata), .c_rdata(c_rdata), .h_irq(h_irq), .c_irq(c_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic hw, input logic [3:0] ha, input logic [31:0] hd,
                       input logic cw, input logic cr, input logic [3:0] ca,
                       input logic [4:0] cd);
    @(negedge clk);
    h_wr = hw; h_addr = ha; h_wdata = hd;
    c_wr = cw; c_rd = cr; c_addr = ca; c_wdata = cd;
    #1;
    hs = h_rdata; cs = c_rdata; hirq_s = h_irq; cirq_s = c_irq;
    @(posedge clk);
    #1;
    h_wr = 1'b0; c_wr = 1'b0; c_rd = 1'b0;
  endtask

  task automatic hwrite(input logic [3:0] a, input logic [31:0] d);
    drive(1'b1, a, d, 1'b0, 1'b0, 4'hC, 5'd0);
  endtask
  task automatic cwrite(input logic [4:0] d);
    drive(1'b0, 4'h4, 32'd0, 1'b1, 1'b0, 4'hC, d);
  endtask
  task automatic look(input logic [3:0] ha, input logic [3:0] ca);
    drive(1'b0, ha, 32'd0, 1'b0, 1'b0, ca, 5'd0);
  endtask
  task automatic push_word(input logic [31:0] d, input bit track);
    hwrite(4'h0, d);
    if (track) exp_q.push_back(d);
  endtask
  task automatic pop_word();
    drive(1'b0, 4'h4, 32'd0, 1'b0, 1'b1, 4'h8, 5'd0);
    got_q.push_back(cs);
  endtask

  // scoreboard monitor: compares popped words against pushed order (R4)
  initial begin
    forever begin
      wait (got_q.size() != 0);
      if (exp_q.size() == 0) chk("R4 unexpected pop", got_q.pop_front(), 32'hxxxx_xxxx);
      else chk("R4 pop order", got_q.pop_front(), exp_q.pop_front());
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    look(4'h4, 4'hC);
    chk("R1 host csr", hs, 32'h0800_0000);
    chk("R1 ctrl csr", cs, 32'h0800_0000);
    chk("R1 irqs", {30'd0, hirq_s, cirq_s}, 32'd0);
    // ready handshake, cross-visible (R11)
    cwrite(5'h08);
    hwrite(4'h4, 32'h08);
    look(4'hC, 4'h4);
    chk("R11 host sees ctrl ready", hs, 32'h0800_0008);
    chk("R11 ctrl sees host ready", cs, 32'h0800_0008);
    // R2/R3 pushes
    push_word(32'h11, 1); push_word(32'h22, 1); push_word(32'h33, 1);
    look(4'h4, 4'hC);
    chk("R2 wp after 3 pushes", hs, 32'h0803_0008);
    pop_word(); pop_word();
    look(4'h4, 4'hC);
    chk("R4 rp after 2 pops", cs, 32'h0803_0208);
    chk("R3 free slots", 32'(cs[31:24] - 8'(cs[23:16] - cs[15:8])), 32'd7);
    // R6 overflow
    for (int i = 0; i < 7; i++) push_word(32'h100 + i, 1);
    push_word(32'hDEAD, 0);
    look(4'h4, 4'hC);
    chk("R6 full drop and overflow", hs, 32'h080A_0228);
    for (int i = 0; i < 8; i++) pop_word();
    // R5 empty pop
    drive(1'b0, 4'h4, 32'd0, 1'b0, 1'b1, 4'h8, 5'd0);
    chk("R5 empty pop data", cs, 32'd0);
    look(4'h4, 4'hC);
    chk("R5 rp unchanged", cs, 32'h080A_0A08);
    hwrite(4'h4, 32'h28);
    look(4'h4, 4'hC);
    chk("R6 overflow cleared", hs, 32'h080A_0A08);
    // R3 wrap
    for (int i = 0; i < 244; i++) begin push_word(32'h5000 + i, 1); pop_word(); end
    look(4'h4, 4'hC);
    chk("R3 pointers near wrap", hs, 32'h08FE_FE08);
    push_word(32'hA0, 1); push_word(32'hA1, 1); push_word(32'hA2, 1);
    look(4'h4, 4'hC);
    chk("R3 wrapped pointers", hs, 32'h0801_FE08);
    chk("R3 wrapped fill", 32'(8'(hs[23:16] - hs[15:8])), 32'd3);
    pop_word(); pop_word(); pop_word();
    // R7/R8/R9 doorbells
    hwrite(4'h4, 32'h0C);
    look(4'h4, 4'hC);
    chk("R7 host bell reads 1", hs, 32'h0801_010C);
    look(4'h4, 4'hC);
    chk("R7 bell self clears", hs, 32'h0801_0108);
    chk("R7 ctrl status set", cs, 32'h0801_010A);
    chk("R9 ctrl irq off when disabled", {31'd0, cirq_s}, 32'd0);
    cwrite(5'h08);
    look(4'h4, 4'hC);
    chk("R8 write 0 keeps status", cs, 32'h0801_010A);
    cwrite(5'h09);
    look(4'h4, 4'hC);
    chk("R9 ctrl irq on", {31'd0, cirq_s}, 32'd1);
    cwrite(5'h0B);
    look(4'h4, 4'hC);
    chk("R8 write 1 clears status", cs, 32'h0801_0109);
    chk("R9 ctrl irq off after clear", {31'd0, cirq_s}, 32'd0);
    cwrite(5'h0D);
    look(4'h4, 4'hC);
    look(4'h4, 4'hC);
    chk("R7 host status from ctrl bell", hs, 32'h0801_010A);
    chk("R9 host irq off when disabled", {31'd0, hirq_s}, 32'd0);
    hwrite(4'h4, 32'h09);
    look(4'h4, 4'hC);
    chk("R9 host irq on", {31'd0, hirq_s}, 32'd1);
    hwrite(4'h4, 32'h0B);
    look(4'h4, 4'hC);
    chk("R9 host irq off after clear", {31'd0, hirq_s}, 32'd0);
    // R10 reset handshake
    push_word(32'hB1, 0); push_word(32'hB2, 0);
    hwrite(4'h4, 32'h14);
    look(4'h4, 4'hC);
    chk("R10 pointers zero, reset set", hs, 32'h0800_0014);
    look(4'h4, 4'hC);
    chk("R10 ctrl ready dropped", cs, 32'h0800_0003);
    chk("R7 reset bell raises ctrl irq", {31'd0, cirq_s}, 32'd1);
    push_word(32'h55, 0);
    look(4'h4, 4'hC);
    chk("R10 write dropped during reset", hs, 32'h0800_0010);
    cwrite(5'h0B);
    look(4'hC, 4'hC);
    chk("R11 host sees ctrl ready again", hs, 32'h0800_0009);
    hwrite(4'h4, 32'h08);
    look(4'h4, 4'hC);
    chk("R10 reset released", hs, 32'h0800_0008);
    chk("R11 ctrl ready kept by host write", cs, 32'h0800_0009);
    push_word(32'h77, 1);
    look(4'h4, 4'hC);
    chk("R2 push after recovery", hs, 32'h0801_0008);
    pop_word();
    repeat (4) @(negedge clk);
    chk("R4 scoreboard drained", 32'(exp_q.size()), 32'd0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule